// File: doc/BRIEF.md
# Nibble ALU with Decimal Adjust

This block is the purely combinational arithmetic and logic unit of a nibble-wide controller. Each cycle it takes the accumulator value, a second operand, the current carry flag and a 4-bit operation code. It returns the new accumulator value, the new carry value, a strobe saying whether the carry flag should be written, and a zero indication used by the zero and non-zero branch tests.

The operation set covers binary addition and subtraction, each with and without the incoming carry. It also covers bitwise AND, OR and XOR, increment and decrement, four rotate forms, and a decimal correction step used after a BCD addition. Subtraction reports "no borrow" as a carry of 1. The surrounding core owns the registers, operand fetch and decoding. It writes `carry_o` into its flag only when `carry_we_o` is high.

Top module: `nib_alu`

## Requirements
- R1: Code 0 returns acc+opnd and code 1 returns acc+opnd+cf_i, both modulo 16, with carry_o equal to the fifth bit of the full sum.
- R2: Code 2 returns acc+~opnd+1 and code 3 returns acc+~opnd+cf_i, both modulo 16. carry_o is the fifth bit of that sum, so it is 1 exactly when no borrow occurs.
- R3: For code 13, when acc exceeds 9 or cf_i is 1, the result is acc+6 modulo 16 and carry_o is 1. Otherwise the result is acc and carry_o equals cf_i. This operation never clears the carry.
- R4: Code 7 returns acc+1 and code 8 returns acc-1, both wrapping modulo 16. Neither writes the carry.
- R5: Code 9 rotates left and copies bit 3 into both bit 0 and carry_o. Code 11 rotates right and copies bit 0 into both bit 3 and carry_o.
- R6: Code 10 shifts left with cf_i entering bit 0 and bit 3 leaving to carry_o. Code 12 shifts right with cf_i entering bit 3 and bit 0 leaving to carry_o.
- R7: Codes 4, 5 and 6 return acc AND opnd, acc OR opnd and acc XOR opnd. None of them writes the carry.
- R8: zero_o is 1 exactly when the 4-bit result is 0, for every code.
- R9: carry_we_o is 1 for codes 0-3 and 9-13 and 0 for every other code. Whenever carry_we_o is 0, carry_o equals cf_i.
- R10: The unused codes 14 and 15 return acc unchanged, with carry_we_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | DATA_W | Accumulator operand |
| opnd_i | input | DATA_W | Second operand (memory or immediate) |
| cf_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | DATA_W | Operation result |
| carry_o | output | 1 | Next carry value |
| carry_we_o | output | 1 | Carry flag write strobe |
| zero_o | output | 1 | Result equals zero |

## Verification
The bench builds the block with its default DATA_W of 4, the only width for which decimal adjust has meaning. At that width every combination of accumulator, operand and incoming carry is only 512 vectors per code. Each scenario can therefore sweep its codes exhaustively, which reaches every wrap at 15/0, every borrow edge and every decimal threshold between 9 and 10.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_ROL  = 4'd9,
    OP_RLC  = 4'd10,
    OP_ROR  = 4'd11,
    OP_RRC  = 4'd12,
    OP_DAA  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/nib_alu_adder.sv
module nib_alu_adder
  import nib_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cf_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int unsigned EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [EXT_W-1:0]  full;

  // one adder serves add, subtract, increment and decrement
  always_comb begin
    b_eff = '0;
    cin   = 1'b0;
    unique case (op_i)
      OP_ADD: begin b_eff = b_i;  cin = 1'b0; end
      OP_ADC: begin b_eff = b_i;  cin = cf_i; end
      OP_SUB: begin b_eff = ~b_i; cin = 1'b1; end
      OP_SBC: begin b_eff = ~b_i; cin = cf_i; end
      OP_INC: begin b_eff = '0;   cin = 1'b1; end
      OP_DEC: begin b_eff = '1;   cin = 1'b0; end
      default: begin b_eff = '0;  cin = 1'b0; end
    endcase
  end

  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
endmodule

// File: rtl/nib_alu_bitops.sv
module nib_alu_bitops
  import nib_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cf_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    res_o  = a_i;
    cout_o = cf_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_ROL: begin res_o = {a_i[MSB-1:0], a_i[MSB]}; cout_o = a_i[MSB]; end
      OP_RLC: begin res_o = {a_i[MSB-1:0], cf_i};     cout_o = a_i[MSB]; end
      OP_ROR: begin res_o = {a_i[0], a_i[MSB:1]};     cout_o = a_i[0];   end
      OP_RRC: begin res_o = {cf_i, a_i[MSB:1]};       cout_o = a_i[0];   end
      default: begin res_o = a_i; cout_o = cf_i; end
    endcase
  end
endmodule

// File: rtl/nib_alu_dec_adj.sv
module nib_alu_dec_adj #(
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam logic [DATA_W-1:0] DIGIT_MAX = DATA_W'(9);
  localparam logic [DATA_W-1:0] ADJ_STEP  = DATA_W'(6);

  logic fix;

  assign fix    = (a_i > DIGIT_MAX) || cf_i;
  assign res_o  = fix ? a_i + ADJ_STEP : a_i;
  // sticky: only ever sets the carry
  assign cout_o = fix;
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cf_i,
  input  logic [3:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_we_o,
  output logic              zero_o
);
  localparam int unsigned EXT_W = DATA_W + 1;

  alu_op_e           op;
  logic [DATA_W-1:0] add_sum, bit_res, daa_res;
  logic              add_c, bit_c, daa_c;

  assign op = alu_op_e'(op_i);

  nib_alu_adder #(.DATA_W(DATA_W)) u_adder (
    .a_i(acc_i), .b_i(opnd_i), .cf_i(cf_i), .op_i(op),
    .sum_o(add_sum), .cout_o(add_c)
  );

  nib_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .a_i(acc_i), .b_i(opnd_i), .cf_i(cf_i), .op_i(op),
    .res_o(bit_res), .cout_o(bit_c)
  );

  nib_alu_dec_adj #(.DATA_W(DATA_W)) u_dec_adj (
    .a_i(acc_i), .cf_i(cf_i), .res_o(daa_res), .cout_o(daa_c)
  );

  always_comb begin
    result_o   = acc_i;
    carry_o    = cf_i;
    carry_we_o = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        result_o = add_sum; carry_o = add_c; carry_we_o = 1'b1;
      end
      OP_INC, OP_DEC: result_o = add_sum;
      OP_AND, OP_OR, OP_XOR: result_o = bit_res;
      OP_ROL, OP_RLC, OP_ROR, OP_RRC: begin
        result_o = bit_res; carry_o = bit_c; carry_we_o = 1'b1;
      end
      OP_DAA: begin
        result_o = daa_res; carry_o = daa_c; carry_we_o = 1'b1;
      end
      default: begin
        result_o = acc_i; carry_o = cf_i; carry_we_o = 1'b0;
      end
    endcase
  end

  assign zero_o = (result_o == '0);

  // port-level checks against independent arithmetic
  logic [EXT_W-1:0] ref_add;
  assign ref_add = {1'b0, acc_i} + {1'b0, opnd_i};

  always_comb begin
    if (op == OP_ADD)
      p_add_carry_r1: assert (carry_o == ref_add[DATA_W] && carry_we_o);
    if (op == OP_SUB)
      p_sub_noborrow_r2: assert (carry_o == (acc_i >= opnd_i));
    if (op == OP_DAA && cf_i)
      p_daa_sticky_r3: assert (carry_o);
    if (op == OP_INC || op == OP_DEC)
      p_incdec_hold_r4: assert (!carry_we_o && carry_o == cf_i);
    if (op == OP_ROL)
      p_rol_mirror_r5: assert (result_o[0] == carry_o);
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      p_logic_hold_r7: assert (!carry_we_o);
    if (!carry_we_o)
      p_carry_pass_r9: assert (carry_o == cf_i);
    if (op == OP_RSV0 || op == OP_RSV1)
      p_rsv_pass_r10: assert (result_o == acc_i && !carry_we_o);
  end
endmodule

// File: tb/nib_alu_tb_top.sv
module nib_alu_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] acc, opnd;
  logic         cf;
  logic [3:0]   op;
  logic [W-1:0] res;
  logic         c_o, we_o, z_o;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  nib_alu #(.DATA_W(W)) dut_i (
    .acc_i(acc), .opnd_i(opnd), .cf_i(cf), .op_i(op),
    .result_o(res), .carry_o(c_o), .carry_we_o(we_o), .zero_o(z_o)
  );

  // expected model written from the requirements
  task automatic model(input int o, input int a, input int b, input int c,
                       output int r, output int co, output int we);
    int s;
    r = a; co = c; we = 0;
    case (o)
      0: begin s = a + b;          r = s % 16; co = s / 16; we = 1; end
      1: begin s = a + b + c;      r = s % 16; co = s / 16; we = 1; end
      2: begin s = a + (15 - b) + 1; r = s % 16; co = s / 16; we = 1; end
      3: begin s = a + (15 - b) + c; r = s % 16; co = s / 16; we = 1; end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = (a + 1) % 16;
      8: r = (a + 15) % 16;
      9:  begin r = ((a * 2) % 16) + a / 8; co = a / 8; we = 1; end
      10: begin r = ((a * 2) % 16) + c;     co = a / 8; we = 1; end
      11: begin r = (a % 2) * 8 + a / 2;    co = a % 2; we = 1; end
      12: begin r = c * 8 + a / 2;          co = a % 2; we = 1; end
      13: begin
        if (a > 9 || c == 1) begin r = (a + 6) % 16; co = 1; end
        we = 1;
      end
      default: ;
    endcase
  endtask

  task automatic apply_chk(input string tag, input int o, input int a,
                           input int b, input int c);
    int er, ec, ew, ez;
    @(negedge clk);
    op = 4'(o); acc = W'(a); opnd = W'(b); cf = 1'(c);
    #5;
    model(o, a, b, c, er, ec, ew);
    ez = (er == 0);
    n_chk++;
    if (int'(res) != er || int'(c_o) != ec || int'(we_o) != ew || int'(z_o) != ez) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d c=%0d: got r=%0d c=%0d we=%0d z=%0d exp r=%0d c=%0d we=%0d z=%0d",
               tag, o, a, b, c, res, c_o, we_o, z_o, er, ec, ew, ez);
    end
  endtask

  task automatic sweep(input string tag, input int o);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          apply_chk(tag, o, a, b, c);
  endtask

  task automatic t_idle;      apply_chk("R8 idle zero", 0, 0, 0, 0); endtask
  task automatic t_add;       sweep("R1", 0); sweep("R1", 1); endtask
  task automatic t_sub;       sweep("R2", 2); sweep("R2", 3); endtask
  task automatic t_daa;
    sweep("R3", 13);
    apply_chk("R3 edge9", 13, 9, 0, 0);
    apply_chk("R3 edge10", 13, 10, 0, 0);
  endtask
  task automatic t_incdec;
    sweep("R4", 7); sweep("R4", 8);
    apply_chk("R4 wrap15", 7, 15, 0, 1);
    apply_chk("R4 wrap0", 8, 0, 0, 1);
  endtask
  task automatic t_rot_plain; sweep("R5", 9);  sweep("R5", 11); endtask
  task automatic t_rot_carry; sweep("R6", 10); sweep("R6", 12); endtask
  task automatic t_logic;     sweep("R7", 4); sweep("R7", 5); sweep("R7", 6); endtask
  task automatic t_we;
    for (int o = 0; o < 16; o++) apply_chk("R9 strobe", o, 5, 3, 1);
  endtask
  task automatic t_unused;    sweep("R10", 14); sweep("R10", 15); endtask

  initial begin
    acc = '0; opnd = '0; cf = 1'b0; op = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_idle;
    t_add;
    t_sub;
    t_daa;
    t_incdec;
    t_rot_plain;
    t_rot_carry;
    t_logic;
    t_we;
    t_unused;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule